// File: doc/BRIEF.md
# Pointer-Driven Kernel MAC Engine

This block performs the inner loop of a dot-product kernel. It keeps two local operand stores, one holding resident weights and one holding streamed operands, each holding 256 signed 32-bit elements. It also keeps two 16-bit address pointers, one per store, and a 64-bit signed running sum. Each step strobe fetches one element from each store at the pointer positions, multiplies the pair as signed numbers, adds the product into the running sum, and moves both pointers forward by one. All of this happens in a single clock.

A surrounding controller fills the stores through two independent write ports and sets either pointer to a start position. It clears the sum, issues one step strobe per element pair, and reads the sum back. A one-cycle completion flag follows every step. The pointers keep their full 16-bit value, but only their low 8 bits select a store entry.

Top module: `ptr_mac_engine`

## Requirements
- R1: After reset the sum, both pointers and the completion flag are zero.
- R2: A step strobe adds the signed product of weight entry [wptr bits 7:0] and stream entry [sptr bits 7:0] to the sum, and the new sum is visible after that clock edge. Elements are two's-complement 32-bit values. Without a step or clear, the sum holds.
- R3: The sum is a 64-bit two's-complement register that wraps modulo 2^64. When the true total fits the signed 64-bit range, the result is exact.
- R4: On a step, both pointers advance by one on the same edge. The entries read for that step are the ones at the pointer values from before the advance.
- R5: A pointer advance wraps modulo 2^16 (0xFFFF goes to 0x0000, 0x00FF goes to 0x0100). Stores are indexed by the low 8 pointer bits only, so pointer 0x0100 reads entry 0.
- R6: Loading one pointer leaves the other unchanged. If a load and a step hit the same pointer in the same cycle, the loaded value wins, and that step still reads at the old pointer value.
- R7: A clear sets the sum to zero. A clear together with a step yields a zero sum, and both pointers still advance.
- R8: A store write does not disturb the read path. A step that reads an entry being written in the same cycle uses the old contents, and later steps see the new contents.
- R9: The completion flag is high for exactly the one cycle after each step strobe and low after any cycle without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_we | input | 1 | Weight store write enable |
| wt_waddr | input | 8 | Weight store write index |
| wt_wdata | input | 32 | Weight store write data |
| st_we | input | 1 | Stream store write enable |
| st_waddr | input | 8 | Stream store write index |
| st_wdata | input | 32 | Stream store write data |
| wptr_ld | input | 1 | Load the weight pointer |
| wptr_ld_val | input | 16 | Value for the weight pointer load |
| sptr_ld | input | 1 | Load the stream pointer |
| sptr_ld_val | input | 16 | Value for the stream pointer load |
| acc_clr | input | 1 | Clear the sum |
| mac_go | input | 1 | Step strobe |
| acc_out | output | 64 | Running sum |
| wptr_out | output | 16 | Current weight pointer |
| sptr_out | output | 16 | Current stream pointer |
| done | output | 1 | Completion flag, one cycle after each step |

## Verification
The properties assume that every control input is a known 0 or 1 at each rising edge once reset is released. They also assume that pointer load values are known whenever their load strobe is high. The pointer-advance properties apply only in cycles without a load on that pointer, because a load overrides the advance. The bench changes all inputs on the falling edge from tasks and returns every strobe to zero after one cycle. It writes every store entry before any step reads it, so no step draws on unwritten contents.

// File: rtl/ptr_mac_pkg.sv
package ptr_mac_pkg;

    localparam int unsigned DEF_ELEM_W = 32;
    localparam int unsigned DEF_ACC_W  = 64;
    localparam int unsigned DEF_PTR_W  = 16;
    localparam int unsigned DEF_IDX_W  = 8;

    // Next-state selection for one pointer
    typedef enum logic [1:0] {
        PTR_HOLD = 2'd0,
        PTR_STEP = 2'd1,
        PTR_LOAD = 2'd2
    } ptr_op_e;

endpackage

// File: rtl/pmac_opmem.sv
module pmac_opmem #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Write lands on the edge; the read in the same cycle sees old contents
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/pmac_ptr_next.sv
module pmac_ptr_next
    import ptr_mac_pkg::*;
#(
    parameter int unsigned PTR_W = 16
) (
    input  ptr_op_e          op,
    input  logic [PTR_W-1:0] cur,
    input  logic [PTR_W-1:0] ld_val,
    output logic [PTR_W-1:0] nxt
);
    always_comb begin
        unique case (op)
            PTR_STEP: nxt = cur + PTR_W'(1);
            PTR_LOAD: nxt = ld_val;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/pmac_product.sv
module pmac_product #(
    parameter int unsigned ELEM_W = 32,
    parameter int unsigned ACC_W  = 64
) (
    input  logic [ELEM_W-1:0] a,
    input  logic [ELEM_W-1:0] b,
    output logic [ACC_W-1:0]  p
);
    localparam int unsigned FULL_W = 2 * ELEM_W;

    logic signed [FULL_W-1:0] full;

    assign full = FULL_W'($signed(a)) * FULL_W'($signed(b));

    generate
        if (ACC_W >= FULL_W) begin : g_extend
            assign p = ACC_W'(full);
        end else begin : g_trunc
            assign p = full[ACC_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/ptr_mac_engine.sv
module ptr_mac_engine
    import ptr_mac_pkg::*;
#(
    parameter int unsigned ELEM_W = DEF_ELEM_W,
    parameter int unsigned ACC_W  = DEF_ACC_W,
    parameter int unsigned PTR_W  = DEF_PTR_W,
    parameter int unsigned IDX_W  = DEF_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wt_we,
    input  logic [IDX_W-1:0]  wt_waddr,
    input  logic [ELEM_W-1:0] wt_wdata,
    input  logic              st_we,
    input  logic [IDX_W-1:0]  st_waddr,
    input  logic [ELEM_W-1:0] st_wdata,
    input  logic              wptr_ld,
    input  logic [PTR_W-1:0]  wptr_ld_val,
    input  logic              sptr_ld,
    input  logic [PTR_W-1:0]  sptr_ld_val,
    input  logic              acc_clr,
    input  logic              mac_go,
    output logic [ACC_W-1:0]  acc_out,
    output logic [PTR_W-1:0]  wptr_out,
    output logic [PTR_W-1:0]  sptr_out,
    output logic              done
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] sptr;
        logic             done;
    } eng_state_t;

    eng_state_t st_q, st_d;

    logic [ELEM_W-1:0] wt_rd, sm_rd;
    logic [ACC_W-1:0]  prod;
    logic [PTR_W-1:0]  wptr_nxt, sptr_nxt;
    ptr_op_e           wop, sop;

    // Operand stores, read at the low pointer bits
    pmac_opmem #(.DATA_W(ELEM_W), .IDX_W(IDX_W)) u_wt_mem (
        .clk   (clk),
        .we    (wt_we),
        .waddr (wt_waddr),
        .wdata (wt_wdata),
        .raddr (st_q.wptr[IDX_W-1:0]),
        .rdata (wt_rd)
    );

    pmac_opmem #(.DATA_W(ELEM_W), .IDX_W(IDX_W)) u_sm_mem (
        .clk   (clk),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (st_wdata),
        .raddr (st_q.sptr[IDX_W-1:0]),
        .rdata (sm_rd)
    );

    pmac_product #(.ELEM_W(ELEM_W), .ACC_W(ACC_W)) u_prod (
        .a (wt_rd),
        .b (sm_rd),
        .p (prod)
    );

    // Load overrides the step advance on the same pointer
    assign wop = wptr_ld ? PTR_LOAD : (mac_go ? PTR_STEP : PTR_HOLD);
    assign sop = sptr_ld ? PTR_LOAD : (mac_go ? PTR_STEP : PTR_HOLD);

    pmac_ptr_next #(.PTR_W(PTR_W)) u_wptr_nxt (
        .op     (wop),
        .cur    (st_q.wptr),
        .ld_val (wptr_ld_val),
        .nxt    (wptr_nxt)
    );

    pmac_ptr_next #(.PTR_W(PTR_W)) u_sptr_nxt (
        .op     (sop),
        .cur    (st_q.sptr),
        .ld_val (sptr_ld_val),
        .nxt    (sptr_nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = mac_go;
        st_d.wptr = wptr_nxt;
        st_d.sptr = sptr_nxt;
        if (acc_clr) begin
            st_d.acc = '0;
        end else if (mac_go) begin
            st_d.acc = st_q.acc + prod;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_out  = st_q.acc;
    assign wptr_out = st_q.wptr;
    assign sptr_out = st_q.sptr;
    assign done     = st_q.done;

endmodule

// File: rtl/ptr_mac_engine_chk.sv
module ptr_mac_engine_chk #(
    parameter int unsigned ACC_W = 64,
    parameter int unsigned PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mac_go,
    input logic             acc_clr,
    input logic             wptr_ld,
    input logic [PTR_W-1:0] wptr_ld_val,
    input logic             sptr_ld,
    input logic [PTR_W-1:0] sptr_ld_val,
    input logic [ACC_W-1:0] acc_out,
    input logic [PTR_W-1:0] wptr_out,
    input logic [PTR_W-1:0] sptr_out,
    input logic             done
);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mac_go |=> done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mac_go |=> !done);

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> (acc_out == '0));

    p_acc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mac_go && !acc_clr) |=> $stable(acc_out));

    p_wptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_go && !wptr_ld) |=> ((wptr_out - $past(wptr_out)) == PTR_W'(1)));

    p_sptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_go && !sptr_ld) |=> ((sptr_out - $past(sptr_out)) == PTR_W'(1)));

    p_wptr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wptr_ld |=> (wptr_out == $past(wptr_ld_val)));

    p_sptr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sptr_ld |=> (sptr_out == $past(sptr_ld_val)));

    p_wptr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wptr_ld && !mac_go) |=> $stable(wptr_out));

    p_sptr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sptr_ld && !mac_go) |=> $stable(sptr_out));

endmodule

bind ptr_mac_engine ptr_mac_engine_chk #(.ACC_W(ACC_W), .PTR_W(PTR_W)) u_chk (.*);

// File: tb/ptr_mac_engine_test.sv
module ptr_mac_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wt_we = 1'b0, st_we = 1'b0;
    logic [7:0]  wt_waddr = '0, st_waddr = '0;
    logic [31:0] wt_wdata = '0, st_wdata = '0;
    logic        wptr_ld = 1'b0, sptr_ld = 1'b0;
    logic [15:0] wptr_ld_val = '0, sptr_ld_val = '0;
    logic        acc_clr = 1'b0, mac_go = 1'b0;
    logic [63:0] acc_out;
    logic [15:0] wptr_out, sptr_out;
    logic        done;

    int checks = 0;
    int errors = 0;

    // Reference state built from the requirements
    logic [31:0] ref_w [256];
    logic [31:0] ref_s [256];
    logic [63:0] ref_acc = '0;
    logic [15:0] ref_wp = '0, ref_sp = '0;
    logic        ref_done = 1'b0;

    always #5 clk = ~clk;

    ptr_mac_engine uut (
        .clk(clk), .rst_n(rst_n),
        .wt_we(wt_we), .wt_waddr(wt_waddr), .wt_wdata(wt_wdata),
        .st_we(st_we), .st_waddr(st_waddr), .st_wdata(st_wdata),
        .wptr_ld(wptr_ld), .wptr_ld_val(wptr_ld_val),
        .sptr_ld(sptr_ld), .sptr_ld_val(sptr_ld_val),
        .acc_clr(acc_clr), .mac_go(mac_go),
        .acc_out(acc_out), .wptr_out(wptr_out), .sptr_out(sptr_out),
        .done(done)
    );

    function automatic logic [63:0] sprod(logic [31:0] a, logic [31:0] b);
        longint x, y;
        x = longint'($signed(a));
        y = longint'($signed(b));
        return 64'(x * y);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk({tag, " acc"}, acc_out, ref_acc);
        chk({tag, " wptr"}, {48'd0, wptr_out}, {48'd0, ref_wp});
        chk({tag, " sptr"}, {48'd0, sptr_out}, {48'd0, ref_sp});
        chk({tag, " done"}, {63'd0, done}, {63'd0, ref_done});
    endtask

    // Inputs already set after a falling edge; advance one cycle and update reference
    task automatic tick();
        logic [63:0] nacc;
        logic [15:0] nwp, nsp;
        nacc = ref_acc;
        if (acc_clr) nacc = '0;
        else if (mac_go) nacc = ref_acc + sprod(ref_w[ref_wp[7:0]], ref_s[ref_sp[7:0]]);
        nwp = wptr_ld ? wptr_ld_val : (mac_go ? ref_wp + 16'd1 : ref_wp);
        nsp = sptr_ld ? sptr_ld_val : (mac_go ? ref_sp + 16'd1 : ref_sp);
        if (wt_we) ref_w[wt_waddr] = wt_wdata;
        if (st_we) ref_s[st_waddr] = st_wdata;
        @(negedge clk);
        ref_acc = nacc; ref_wp = nwp; ref_sp = nsp; ref_done = mac_go;
        wt_we = 0; st_we = 0; wptr_ld = 0; sptr_ld = 0; acc_clr = 0; mac_go = 0;
    endtask

    task automatic load_ptrs(logic [15:0] w, logic [15:0] s);
        wptr_ld = 1; wptr_ld_val = w; sptr_ld = 1; sptr_ld_val = s;
        tick();
    endtask

    task automatic clear_acc();
        acc_clr = 1;
        tick();
    endtask

    task automatic step();
        mac_go = 1;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 acc", acc_out, 64'd0);
        chk("R1 wptr", {48'd0, wptr_out}, 64'd0);
        chk("R1 sptr", {48'd0, sptr_out}, 64'd0);
        chk("R1 done", {63'd0, done}, 64'd0);
    endtask

    task automatic t_preload();
        for (int i = 0; i < 256; i++) begin
            wt_we = 1; wt_waddr = 8'(i); wt_wdata = 32'(i * 37 + 3) ^ ((i % 3 == 0) ? 32'hFFFF_0000 : 32'h0);
            st_we = 1; st_waddr = 8'(i); st_wdata = (i % 2 == 1) ? -32'(i * 1001) : 32'(i * 513 + 7);
            tick();
        end
    endtask

    task automatic t_basic();
        clear_acc();
        load_ptrs(16'd4, 16'd9);
        for (int k = 0; k < 5; k++) begin
            step();
            chk_all("R2 R4 R9 basic");
        end
        mac_go = 0;
        tick();
        chk_all("R9 idle after step");
        chk("R9 done low", {63'd0, done}, 64'd0);
    endtask

    task automatic t_signed();
        wt_we = 1; wt_waddr = 8'd50; wt_wdata = 32'hFFFF_FFFD;
        st_we = 1; st_waddr = 8'd60; st_wdata = 32'd7;
        tick();
        clear_acc();
        load_ptrs(16'd50, 16'd60);
        step();
        chk("R2 signed product -21", acc_out, 64'hFFFF_FFFF_FFFF_FFEB);
        chk_all("R2 signed");
    endtask

    task automatic t_wrap();
        for (int i = 200; i < 204; i++) begin
            wt_we = 1; wt_waddr = 8'(i); wt_wdata = 32'h8000_0000;
            st_we = 1; st_waddr = 8'(i); st_wdata = 32'h8000_0000;
            tick();
        end
        clear_acc();
        load_ptrs(16'd200, 16'd200);
        step();
        chk("R3 exact 2^62", acc_out, 64'h4000_0000_0000_0000);
        step();
        step();
        chk("R3 wrap 3*2^62", acc_out, 64'hC000_0000_0000_0000);
        step();
        chk("R3 wrap to zero", acc_out, 64'd0);
    endtask

    task automatic t_ptr_wrap();
        clear_acc();
        load_ptrs(16'hFFFF, 16'h00FF);
        step();
        chk("R5 wptr wraps 16 bit", {48'd0, wptr_out}, 64'h0000);
        chk("R5 sptr to 0x0100", {48'd0, sptr_out}, 64'h0100);
        chk_all("R5 first");
        step();
        chk_all("R5 low-bit index");
    endtask

    task automatic t_load_indep();
        load_ptrs(16'd10, 16'd20);
        wptr_ld = 1; wptr_ld_val = 16'h1234;
        tick();
        chk("R6 sptr kept", {48'd0, sptr_out}, 64'd20);
        chk("R6 wptr loaded", {48'd0, wptr_out}, 64'h1234);
        clear_acc();
        load_ptrs(16'd30, 16'd40);
        sptr_ld = 1; sptr_ld_val = 16'h0042; mac_go = 1;
        tick();
        chk("R6 sptr load wins", {48'd0, sptr_out}, 64'h0042);
        chk("R6 wptr advanced", {48'd0, wptr_out}, 64'd31);
        chk_all("R6 load with step");
    endtask

    task automatic t_clear_step();
        load_ptrs(16'd70, 16'd80);
        step();
        acc_clr = 1; mac_go = 1;
        tick();
        chk("R7 acc zero", acc_out, 64'd0);
        chk("R7 wptr advanced", {48'd0, wptr_out}, 64'd72);
        chk("R7 sptr advanced", {48'd0, sptr_out}, 64'd82);
        chk_all("R7 clear with step");
    endtask

    task automatic t_collision();
        wt_we = 1; wt_waddr = 8'd90; wt_wdata = 32'd3;
        st_we = 1; st_waddr = 8'd91; st_wdata = 32'd5;
        tick();
        clear_acc();
        load_ptrs(16'd90, 16'd91);
        wt_we = 1; wt_waddr = 8'd90; wt_wdata = 32'd100; mac_go = 1;
        tick();
        chk("R8 old data used", acc_out, 64'd15);
        load_ptrs(16'd90, 16'd91);
        step();
        chk("R8 new data later", acc_out, 64'd515);
        chk_all("R8 collision");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_preload();
        t_basic();
        t_signed();
        t_wrap();
        t_ptr_wrap();
        t_load_indep();
        t_clear_step();
        t_collision();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule